// File: doc/BRIEF.md
# DTMF Tone Burst Generator

This block builds a digital dual-tone telephone signal for one 4-bit key code. A prescaler divides the reference clock into a tone tick. Two square-wave oscillators run on that tick, one for the low-group (row) frequency of the key and one for the high-group (column) frequency. Their levels are added into one signed sample, which a later digital-to-analog stage turns into the line signal.

The block has two ways to send a key. In timed-burst mode a single load starts a tone burst of a fixed length. A silent gap of the same length follows, and a one-cycle completion pulse marks the end. During the burst and the gap, further loads are ignored. In continuous mode a load only latches the key. The tone then sounds for as long as the `tone_on` input stays high.

Top module: `dtmf_burst_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, `sample` is 0 and both `busy` and `done` are 0.
- R2: Key codes choose a row and a column as follows. Row 0 (697 Hz) takes codes 1, 2, 3, 13. Row 1 (770 Hz) takes 4, 5, 6, 14. Row 2 (852 Hz) takes 7, 8, 9, 15. Row 3 (941 Hz) takes 10, 11, 12, 0. Column 0 (1209 Hz) takes 1, 4, 7, 11. Column 1 (1336 Hz) takes 2, 5, 8, 10. Column 2 (1477 Hz) takes 3, 6, 9, 12. Column 3 (1633 Hz) takes 13, 14, 15, 0.
- R3: The tick rate is REF_HZ/PRESCALE, and a tick falls every PRESCALE cycles while the block is active. Each tone is a square wave whose half period is round(tick rate / (2·f)) ticks. Each wave starts in its high half. At the default parameters every frequency is within 1% of nominal.
- R4: While a tone sounds, `sample` = (row high ? +ROW_AMP : −ROW_AMP) + (column high ? +COL_AMP : −COL_AMP), in two's complement. While silent, `sample` is 0.
- R5: A load accepted with `burst_mode` = 1 plays the tone for round(tick rate · BURST_MS / 1000) ticks (51 ms by default). A silent gap of the same length follows. `busy` is high for the whole burst and gap, so it stays high for 2·span·PRESCALE cycles.
- R6: `done` is high for exactly one cycle, the first cycle after the gap, and `busy` is low in that cycle.
- R7: A load while `busy` is high changes neither the key nor the waveform. A load that is still held when the gap ends is accepted in the first idle cycle.
- R8: With `burst_mode` = 0, a load latches the key and leaves `busy` low. The tone sounds while `tone_on` is high and a key has been loaded since reset. Otherwise `sample` is 0.
- R9: Every accepted load restarts both waves at the start of their high half, using the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit | input | 4 | Key code to send |
| load | input | 1 | Strobe that latches `digit` when the block is idle |
| burst_mode | input | 1 | 1: a load starts a timed burst; 0: continuous mode |
| tone_on | input | 1 | Continuous-mode sound enable |
| sample | output | SAMPLE_W | Signed sum of the two tone levels |
| busy | output | 1 | High during a burst and its gap |
| done | output | 1 | One-cycle pulse when a burst and its gap have ended |

## Verification
A wrong half-period limit or a wrong key-to-tone lookup makes `sample` flip to the wrong sign. This shows within one half period of the affected tone after the tone starts, so it is caught within about a hundred ticks. A burst-span counter that is off by even one tick moves the fall of `busy` and the `done` pulse by PRESCALE cycles. A key register that takes a load while busy shows as a different waveform in the rest of the burst. Every output is compared in every cycle against a reference model built from the frequency table and the keypad layout, so each of these faults shows at the first cycle it affects.

// File: rtl/dtmf_gen_pkg.sv
package dtmf_gen_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TONE = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;

  // Nominal frequency in Hz: grp 0 = low group, 1 = high group; idx 0..3 ascending.
  function automatic int unsigned group_hz(input int unsigned grp, input int unsigned idx);
    int unsigned f;
    if (grp == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Rounded half period in ticks.
  function automatic int unsigned half_ticks(input int unsigned tick_hz, input int unsigned f);
    return (tick_hz + f) / (2 * f);
  endfunction

  // Rounded number of ticks in a span of ms milliseconds.
  function automatic int unsigned span_ticks(input int unsigned tick_hz, input int unsigned ms);
    longint unsigned prod;
    prod = longint'(tick_hz) * longint'(ms) + 64'd500;
    return int'(prod / 64'd1000);
  endfunction

  // Bits needed to hold the value n.
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic logic [1:0] row_of(input logic [3:0] code);
    logic [1:0] r;
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13:  r = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14:  r = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15:  r = 2'd2;
      default:                  r = 2'd3;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] col_of(input logic [3:0] code);
    logic [1:0] c;
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11:  c = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10:  c = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12:  c = 2'd2;
      default:                  c = 2'd3;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dtmf_prescaler.sv
module dtmf_prescaler
  import dtmf_gen_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = width_for(DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == CW'(DIV - 1));
  assign tick    = run && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart || !run || at_last) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assert_presc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < (CW+1)'(DIV));

  assert_presc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/dtmf_square_osc.sv
module dtmf_square_osc
  import dtmf_gen_pkg::*;
#(
  parameter int unsigned TICK_HZ = 894886,
  parameter int unsigned GROUP   = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tick,
  input  logic [1:0] idx,
  output logic       phase_hi
);
  localparam int unsigned HMAX = half_ticks(TICK_HZ, group_hz(GROUP, 0));
  localparam int unsigned HW   = width_for(HMAX);

  logic [HW-1:0] lim [4];
  logic [HW-1:0] cnt;
  logic          wrap;

  for (genvar i = 0; i < 4; i++) begin : g_lim
    assign lim[i] = HW'(half_ticks(TICK_HZ, group_hz(GROUP, i)) - 1);
  end

  assign wrap = (cnt == lim[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (hold) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (tick) begin
      if (wrap) begin
        cnt      <= '0;
        phase_hi <= ~phase_hi;
      end else begin
        cnt      <= cnt + 1'b1;
      end
    end
  end

  assert_osc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (cnt <= lim[idx]));

  assert_osc_flip_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !tick) |=> $stable(phase_hi));

  assert_osc_start_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> phase_hi);

endmodule

// File: rtl/dtmf_burst_seq.sv
module dtmf_burst_seq
  import dtmf_gen_pkg::*;
#(
  parameter int unsigned SPAN = 45639
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       burst_mode,
  input  logic       tick,
  input  logic [3:0] digit,
  output logic [3:0] code_q,
  output logic       code_valid,
  output logic       accept,
  output logic       busy,
  output logic       tone_live,
  output logic       done
);
  localparam int unsigned CW = width_for(SPAN);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          span_end;

  assign accept    = (state == SEQ_IDLE) && load;
  assign busy      = (state != SEQ_IDLE);
  assign tone_live = (state == SEQ_TONE);
  assign span_end  = tick && (cnt == CW'(SPAN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      code_q     <= '0;
      code_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (accept) begin
            code_q     <= digit;
            code_valid <= 1'b1;
            cnt        <= '0;
            if (burst_mode) state <= SEQ_TONE;
          end
        end
        SEQ_TONE: begin
          if (span_end) begin
            cnt   <= '0;
            state <= SEQ_GAP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (span_end) begin
            cnt   <= '0;
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(code_q));

  assert_tone_then_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tone_live |=> busy);

  assert_span_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < (CW+1)'(SPAN));

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_gen_pkg::*;
#(
  parameter int unsigned REF_HZ   = 3579545,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned BURST_MS = 51,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned ROW_AMP  = 48,
  parameter int unsigned COL_AMP  = 60
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 digit,
  input  logic                       load,
  input  logic                       burst_mode,
  input  logic                       tone_on,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       busy,
  output logic                       done
);
  localparam int unsigned TICK_HZ = REF_HZ / PRESCALE;
  localparam int unsigned SPAN    = span_ticks(TICK_HZ, BURST_MS);
  localparam logic signed [SAMPLE_W-1:0] RA = SAMPLE_W'(ROW_AMP);
  localparam logic signed [SAMPLE_W-1:0] CA = SAMPLE_W'(COL_AMP);

  logic [3:0] code_q;
  logic       code_valid;
  logic       accept;
  logic       tone_live;
  logic       sounding;
  logic       run;
  logic       tick;
  logic       osc_hold;
  logic [1:0] sel [2];
  logic [1:0] phase_hi;

  dtmf_burst_seq #(.SPAN(SPAN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .burst_mode (burst_mode),
    .tick       (tick),
    .digit      (digit),
    .code_q     (code_q),
    .code_valid (code_valid),
    .accept     (accept),
    .busy       (busy),
    .tone_live  (tone_live),
    .done       (done)
  );

  assign sounding = tone_live || (!busy && !burst_mode && tone_on && code_valid);
  assign run      = busy || sounding;
  assign osc_hold = !sounding || accept;

  dtmf_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (accept),
    .tick    (tick)
  );

  assign sel[0] = row_of(code_q);
  assign sel[1] = col_of(code_q);

  for (genvar g = 0; g < 2; g++) begin : g_tone
    dtmf_square_osc #(.TICK_HZ(TICK_HZ), .GROUP(g)) u_osc (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (osc_hold),
      .tick     (tick),
      .idx      (sel[g]),
      .phase_hi (phase_hi[g])
    );
  end

  always_comb begin
    if (sounding) sample = (phase_hi[0] ? RA : -RA) + (phase_hi[1] ? CA : -CA);
    else          sample = '0;
  end

  assert_silent_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tone_on) |-> (sample == '0));

  assert_cont_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load && !burst_mode) |=> !busy);

endmodule

// File: tb/dtmf_burst_gen_test.sv
module dtmf_burst_gen_test;
  localparam int REF   = 400000;
  localparam int P     = 2;
  localparam int MS    = 51;
  localparam int RA    = 48;
  localparam int CA    = 60;
  localparam real TICK_R = real'(REF) / real'(P);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic load = 1'b0;
  logic burst_mode = 1'b0;
  logic tone_on = 1'b0;
  logic signed [7:0] sample;
  logic busy, done;

  dtmf_burst_gen #(.REF_HZ(REF), .PRESCALE(P), .BURST_MS(MS), .SAMPLE_W(8),
                   .ROW_AMP(RA), .COL_AMP(CA)) uut (
    .clk(clk), .rst_n(rst_n), .digit(digit), .load(load), .burst_mode(burst_mode),
    .tone_on(tone_on), .sample(sample), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  typedef struct { int s; bit b; bit d; string tag; } exp_t;
  exp_t sbq[$];

  // Reference values from the frequency table and keypad layout.
  real rowf[4] = '{697.0, 770.0, 852.0, 941.0};
  real colf[4] = '{1209.0, 1336.0, 1477.0, 1633.0};
  string pad[4] = '{"123A", "456B", "789C", "*0#D"};
  int hr[4];
  int hc[4];
  int span_cyc;

  function automatic int key_code(input byte ch);
    if (ch >= "1" && ch <= "9") return ch - "0";
    case (ch)
      "0": return 10;
      "*": return 11;
      "#": return 12;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      default: return 0;
    endcase
  endfunction

  function automatic void locate(input int code, output int r, output int c);
    r = 0; c = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (key_code(pad[i][j]) == code) begin r = i; c = j; end
  endfunction

  // Reference model state.
  int m_st = 0;
  int m_code = 0;
  bit m_valid = 0;
  int m_k = 0;
  int m_t = 0;
  bit m_done = 0;

  function automatic bit model_sound();
    return (m_st == 1) || (m_st == 0 && !burst_mode && tone_on && m_valid);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit snd;
    if (!rst_n) begin
      m_st = 0; m_valid = 0; m_k = 0; m_t = 0; m_done = 0; m_code = 0;
    end else begin
      snd = model_sound();
      case (m_st)
        0: begin
          m_done = 0;
          if (load) begin
            m_code = digit; m_valid = 1; m_k = 0; m_t = 0;
            if (burst_mode) m_st = 1;
          end else if (snd) m_k++;
          else m_k = 0;
        end
        1: begin
          m_done = 0; m_k++; m_t++;
          if (m_t == span_cyc) begin m_st = 2; m_t = 0; end
        end
        default: begin
          m_t++;
          if (m_t == span_cyc) begin m_st = 0; m_t = 0; m_k = 0; m_done = 1; end
          else m_done = 0;
        end
      endcase
    end
  end

  // Expected-item producer.
  always @(negedge clk) begin
    exp_t e;
    int r, c;
    bit rh, ch;
    #3;
    e.tag = cur_req;
    e.b = (m_st != 0);
    e.d = m_done;
    e.s = 0;
    if (rst_n && model_sound()) begin
      locate(m_code, r, c);
      rh = (((m_k / P) / hr[r]) % 2) == 0;
      ch = (((m_k / P) / hc[c]) % 2) == 0;
      e.s = (rh ? RA : -RA) + (ch ? CA : -CA);
    end
    if (!rst_n) begin e.b = 0; e.d = 0; e.s = 0; end
    sbq.push_back(e);
  end

  // Monitor: pops and compares every cycle.
  int run_len = 0;
  int done_seen = 0;
  always @(negedge clk) begin
    exp_t e;
    #4;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      compared++;
      if (int'(sample) != e.s || busy != e.b || done != e.d) begin
        mismatched++;
        $display("FAIL %s at %0t: sample=%0d busy=%b done=%b expected sample=%0d busy=%b done=%b",
                 e.tag, $time, sample, busy, done, e.s, e.b, e.d);
      end
    end
    if (rst_n) begin
      if (busy) run_len++;
      if (done) begin
        done_seen++;
        compared++;
        if (run_len != 2 * span_cyc) begin
          mismatched++;
          $display("FAIL R5 burst length: busy cycles=%0d expected=%0d", run_len, 2 * span_cyc);
        end
        run_len = 0;
      end
    end
  end

  task automatic do_load(input int c, input bit bm);
    @(negedge clk); #1;
    digit = 4'(c); burst_mode = bm; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  task automatic set_tone(input bit v);
    @(negedge clk); #1;
    tone_on = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      hr[i] = $rtoi(TICK_R / (2.0 * rowf[i]) + 0.5);
      hc[i] = $rtoi(TICK_R / (2.0 * colf[i]) + 0.5);
    end
    span_cyc = $rtoi(TICK_R * real'(MS) / 1000.0 + 0.5) * P;

    cur_req = "R1";
    idle(4);
    @(negedge clk); #1; rst_n = 1'b1;
    idle(3);

    // Continuous mode: latched key is silent until tone_on rises (R8).
    cur_req = "R8";
    do_load(5, 1'b0);
    idle(40);
    cur_req = "R2/R3/R4";
    set_tone(1'b1);
    idle(1200);

    // Reloads while sounding restart the waves with the new key (R9, R2).
    cur_req = "R9";
    do_load(0, 1'b0);  idle(1200);
    do_load(11, 1'b0); idle(1200);
    do_load(3, 1'b0);  idle(1200);
    do_load(13, 1'b0); idle(1200);
    do_load(8, 1'b0);  idle(1200);

    cur_req = "R8";
    set_tone(1'b0);
    idle(100);

    // Timed burst with a load during the tone (R5, R7).
    cur_req = "R5";
    do_load(9, 1'b1);
    idle(3000);
    cur_req = "R7";
    do_load(2, 1'b1);
    idle(25000);

    // Hold load through the end of the gap: accepted in the first idle cycle (R6, R7).
    cur_req = "R6/R7";
    @(negedge clk); #1;
    digit = 4'd2; load = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk); #1;
    load = 1'b0;

    // Switch to continuous mid-burst; burst still completes, then tone continues (R5, R8).
    cur_req = "R5";
    idle(5000);
    @(negedge clk); #1;
    burst_mode = 1'b0; tone_on = 1'b1;
    while (!done) @(negedge clk);
    cur_req = "R8";
    idle(1000);
    set_tone(1'b0);
    idle(50);

    compared++;
    if (done_seen != 2) begin
      mismatched++;
      $display("FAIL R6 done pulses: actual=%0d expected=2", done_seen);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule